// File: doc/BRIEF.md
# Software-Generated Interrupt Dispatcher

This block keeps the software-generated interrupt state of a distributor that serves up to eight CPUs. A CPU raises an interrupt by writing a generate register that names an interrupt number, a list of destination CPUs and a filter mode. For every destination that survives the filter, the block records which CPU raised the interrupt. Each destination holds, for each interrupt number, a bitmap of source CPUs. An interrupt is pending for a destination while that bitmap is nonzero.

Two byte-addressable windows of sixteen bytes expose the bitmaps of the accessing CPU. One window ORs written bits into the bitmaps and the other removes them. Each byte of an access is one interrupt's source bitmap, and an access may be one byte or one 32-bit word. Every access carries the identity of the CPU that makes it. A separate input gives the number of active CPUs. The flat pending output has one bit per destination and interrupt number, and it feeds the arbitration logic that follows this block.

Top module: `sgi_dispatch`

## Requirements
- R1: After reset every source bitmap is zero, every `pend_out` bit is low, and every window read returns zero.
- R2: A write with `req_win`=0 (generate) decodes the interrupt number from `req_wdata[3:0]`, the destination list from `req_wdata[23:16]` (bit n = CPU n) and the filter mode from `req_wdata[25:24]`. In mode 0 each listed CPU whose index is below `active_cpus` gets bit `req_cpu` set in that interrupt's bitmap. Listed CPUs at or above `active_cpus` are dropped.
- R3: Mode 1 targets every CPU with index below `active_cpus` except `req_cpu`, and the destination list is ignored.
- R4: Mode 2 targets only `req_cpu`, and the destination list is ignored.
- R5: Mode 3 changes no bitmap and no `pend_out` bit.
- R6: A write with `req_win`=1 (set window) ORs each written byte into the matching bitmap of bank `req_cpu`. Every interrupt whose bitmap is then nonzero is pending.
- R7: A write with `req_win`=2 (clear window) removes the written bits from the bitmaps of bank `req_cpu`. An interrupt stays pending while any source bit remains, and it stops being pending only when its bitmap reaches zero.
- R8: With `req_byte`=1 an access touches only the interrupt numbered `req_offset`, using data byte 0. With `req_byte`=0 it touches four interrupts starting at `req_offset` with its two low bits cleared, and data byte k maps to base+k.
- R9: Reads (combinational `rd_data` while `req_valid` is high and `req_write` is low) of either window return the bitmaps of bank `req_cpu` in the lane order of R8. Unused bytes read zero. Reads of the generate register, or with `req_win`=3, return zero.
- R10: `pend_out[c*16+s]` is high exactly when the bitmap of interrupt s for destination c is nonzero. The output changes only on the clock edge of a write.
- R11: A window write changes only the bank of the accessing CPU.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| active_cpus | input | 4 | Number of active CPUs, 1 to 8 |
| req_valid | input | 1 | Access strobe |
| req_write | input | 1 | 1 = write, 0 = read |
| req_win | input | 2 | 0 generate, 1 set window, 2 clear window, 3 unmapped |
| req_byte | input | 1 | 1 = byte access, 0 = word access |
| req_offset | input | 4 | Byte offset inside the window |
| req_cpu | input | 3 | Identity of the accessing CPU |
| req_wdata | input | 32 | Write data |
| rd_data | output | 32 | Read data, combinational |
| pend_out | output | 128 | Pending flag per destination CPU and interrupt number |

## Verification
The bound checker watches the edges of the pending vector on every cycle. Idle cycles and reads leave it unchanged, set and generate writes never drop a pending bit, clear writes never raise one, and a reserved-mode generate leaves it frozen. Generate and read data also read zero. Only the bench scenarios show which bits change: the filter outcomes per mode against the active count, byte-lane mapping for byte and word accesses, partial clears that keep an interrupt pending, and isolation between banks. The bench checks these against a reference model of the bitmaps.

// File: rtl/sgi_pkg.sv
package sgi_pkg;
   typedef enum logic [1:0] {
      WIN_GEN  = 2'd0,
      WIN_SET  = 2'd1,
      WIN_CLR  = 2'd2,
      WIN_NONE = 2'd3
   } win_e;

   typedef enum logic [1:0] {
      FLT_LIST   = 2'd0,
      FLT_OTHERS = 2'd1,
      FLT_SELF   = 2'd2,
      FLT_RSVD   = 2'd3
   } filt_e;

   localparam int unsigned GEN_LIST_LSB = 16;
   localparam int unsigned GEN_MODE_LSB = 24;
endpackage

// File: rtl/sgi_target_decode.sv
module sgi_target_decode #(
   parameter int unsigned NUM_CPU = 8,
   parameter int unsigned CPU_W   = 3,
   parameter int unsigned CNT_W   = 4
) (
   input  logic [1:0]         mode,
   input  logic [NUM_CPU-1:0] list,
   input  logic [CPU_W-1:0]   cpu,
   input  logic [CNT_W-1:0]   active,
   output logic [NUM_CPU-1:0] tgt
);
   import sgi_pkg::*;

   logic [NUM_CPU-1:0] live;
   logic [NUM_CPU-1:0] self_bit;

   for (genvar i = 0; i < NUM_CPU; i++) begin : g_live
      assign live[i]     = (active > CNT_W'(i));
      assign self_bit[i] = (cpu == CPU_W'(i));
   end

   always_comb begin
      unique case (filt_e'(mode))
         FLT_LIST:   tgt = list & live;
         FLT_OTHERS: tgt = live & ~self_bit;
         FLT_SELF:   tgt = self_bit & live;
         default:    tgt = '0;
      endcase
   end
endmodule

// File: rtl/sgi_lane_decode.sv
module sgi_lane_decode #(
   parameter int unsigned NUM_SGI = 16,
   parameter int unsigned SGI_W   = 4,
   parameter int unsigned LANES   = 4,
   parameter int unsigned LANE_W  = 2
) (
   input  logic [SGI_W-1:0]           offset,
   input  logic                       is_byte,
   input  logic [8*LANES-1:0]         wdata,
   output logic [NUM_SGI-1:0]         hit,
   output logic [NUM_SGI-1:0][7:0]    lane
);
   logic [SGI_W-1:0] base;
   assign base = {offset[SGI_W-1:LANE_W], {LANE_W{1'b0}}};

   for (genvar s = 0; s < NUM_SGI; s++) begin : g_sgi
      logic [SGI_W-1:0] diff;
      assign diff = SGI_W'(s) - base;
      always_comb begin
         if (is_byte) begin
            hit[s]  = (offset == SGI_W'(s));
            lane[s] = wdata[7:0];
         end else begin
            hit[s]  = (diff < SGI_W'(LANES));
            lane[s] = wdata[{diff[LANE_W-1:0], 3'b000} +: 8];
         end
      end
   end
endmodule

// File: rtl/sgi_src_bank.sv
module sgi_src_bank #(
   parameter int unsigned NUM_CPU = 8,
   parameter int unsigned NUM_SGI = 16,
   parameter int unsigned CPU_W   = 3,
   parameter int unsigned SGI_W   = 4
) (
   input  logic                           clk,
   input  logic                           rst_n,
   input  logic                           gen_hit,
   input  logic [SGI_W-1:0]               gen_sgi,
   input  logic [CPU_W-1:0]               gen_src,
   input  logic                           win_set,
   input  logic                           win_clr,
   input  logic [NUM_SGI-1:0]             hit,
   input  logic [NUM_SGI-1:0][7:0]        lane,
   output logic [NUM_SGI-1:0][NUM_CPU-1:0] src
);
   for (genvar s = 0; s < NUM_SGI; s++) begin : g_sgi
      logic [NUM_CPU-1:0] nxt;
      always_comb begin
         nxt = src[s];
         if (gen_hit && gen_sgi == SGI_W'(s)) nxt[gen_src] = 1'b1;
         if (win_set && hit[s]) nxt = nxt | lane[s][NUM_CPU-1:0];
         if (win_clr && hit[s]) nxt = nxt & ~lane[s][NUM_CPU-1:0];
      end
      always_ff @(posedge clk) begin
         if (!rst_n) src[s] <= '0;
         else        src[s] <= nxt;
      end
   end
endmodule

// File: rtl/sgi_dispatch.sv
module sgi_dispatch #(
   parameter int unsigned NUM_CPU = 8,
   parameter int unsigned NUM_SGI = 16,
   parameter int unsigned DATA_W  = 32,
   localparam int unsigned CPU_W  = $clog2(NUM_CPU),
   localparam int unsigned SGI_W  = $clog2(NUM_SGI),
   localparam int unsigned CNT_W  = $clog2(NUM_CPU + 1),
   localparam int unsigned LANES  = DATA_W / 8,
   localparam int unsigned LANE_W = $clog2(LANES)
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic [CNT_W-1:0]           active_cpus,
   input  logic                       req_valid,
   input  logic                       req_write,
   input  logic [1:0]                 req_win,
   input  logic                       req_byte,
   input  logic [SGI_W-1:0]           req_offset,
   input  logic [CPU_W-1:0]           req_cpu,
   input  logic [DATA_W-1:0]          req_wdata,
   output logic [DATA_W-1:0]          rd_data,
   output logic [NUM_CPU*NUM_SGI-1:0] pend_out
);
   import sgi_pkg::*;

   if (NUM_CPU < 2 || NUM_CPU > 8) begin : g_bad_cpu
      $error("NUM_CPU must lie in 2..8");
   end
   if (NUM_SGI != 16) begin : g_bad_sgi
      $error("NUM_SGI must be 16 to match the generate field");
   end
   if (DATA_W != 32) begin : g_bad_data
      $error("DATA_W must be 32 to hold the generate fields");
   end

   win_e               win;
   logic               wr_gen, wr_set, wr_clr;
   logic [NUM_CPU-1:0] tgt;
   logic [NUM_SGI-1:0]      hit;
   logic [NUM_SGI-1:0][7:0] lane;
   logic [NUM_CPU-1:0][NUM_SGI-1:0][NUM_CPU-1:0] bank;

   assign win    = win_e'(req_win);
   assign wr_gen = req_valid && req_write && (win == WIN_GEN);
   assign wr_set = req_valid && req_write && (win == WIN_SET);
   assign wr_clr = req_valid && req_write && (win == WIN_CLR);

   sgi_target_decode #(.NUM_CPU(NUM_CPU), .CPU_W(CPU_W), .CNT_W(CNT_W)) u_tgt (
      .mode   (req_wdata[GEN_MODE_LSB +: 2]),
      .list   (req_wdata[GEN_LIST_LSB +: NUM_CPU]),
      .cpu    (req_cpu),
      .active (active_cpus),
      .tgt    (tgt)
   );

   sgi_lane_decode #(.NUM_SGI(NUM_SGI), .SGI_W(SGI_W), .LANES(LANES), .LANE_W(LANE_W)) u_lane (
      .offset  (req_offset),
      .is_byte (req_byte),
      .wdata   (req_wdata),
      .hit     (hit),
      .lane    (lane)
   );

   for (genvar c = 0; c < NUM_CPU; c++) begin : g_bank
      logic mine;
      assign mine = (req_cpu == CPU_W'(c));
      sgi_src_bank #(.NUM_CPU(NUM_CPU), .NUM_SGI(NUM_SGI), .CPU_W(CPU_W), .SGI_W(SGI_W)) u_bank (
         .clk     (clk),
         .rst_n   (rst_n),
         .gen_hit (wr_gen && tgt[c]),
         .gen_sgi (req_wdata[SGI_W-1:0]),
         .gen_src (req_cpu),
         .win_set (wr_set && mine),
         .win_clr (wr_clr && mine),
         .hit     (hit),
         .lane    (lane),
         .src     (bank[c])
      );
      for (genvar s = 0; s < NUM_SGI; s++) begin : g_pend
         assign pend_out[c*NUM_SGI + s] = |bank[c][s];
      end
   end

   logic [SGI_W-1:0] rd_base;
   logic             rd_win;
   assign rd_base = req_byte ? req_offset : {req_offset[SGI_W-1:LANE_W], {LANE_W{1'b0}}};
   assign rd_win  = req_valid && !req_write && (win == WIN_SET || win == WIN_CLR);

   for (genvar k = 0; k < LANES; k++) begin : g_rd
      logic [SGI_W-1:0] idx;
      logic [7:0]       rb;
      assign idx = rd_base + SGI_W'(k);
      always_comb begin
         rb = '0;
         if (rd_win && (k == 0 || !req_byte)) rb[NUM_CPU-1:0] = bank[req_cpu][idx];
      end
      assign rd_data[8*k +: 8] = rb;
   end

   logic unused_wdata;
   assign unused_wdata = ^{req_wdata[DATA_W-1:GEN_MODE_LSB+2], req_wdata[GEN_LIST_LSB-1:SGI_W]};
endmodule

// File: rtl/sgi_dispatch_chk.sv
module sgi_dispatch_chk #(
   parameter int unsigned NUM_CPU = 8,
   parameter int unsigned NUM_SGI = 16,
   parameter int unsigned DATA_W  = 32
) (
   input logic                       clk,
   input logic                       rst_n,
   input logic                       req_valid,
   input logic                       req_write,
   input logic [1:0]                 req_win,
   input logic [DATA_W-1:0]          req_wdata,
   input logic [DATA_W-1:0]          rd_data,
   input logic [NUM_CPU*NUM_SGI-1:0] pend_out
);
   logic wr_gen, wr_set, wr_clr;
   assign wr_gen = req_valid && req_write && req_win == 2'd0;
   assign wr_set = req_valid && req_write && req_win == 2'd1;
   assign wr_clr = req_valid && req_write && req_win == 2'd2;

   assert_reset_idle_R1: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rst_n) |-> pend_out == '0);

   assert_gen_no_drop_R2: assert property (@(posedge clk) disable iff (!rst_n)
      wr_gen |=> (($past(pend_out) & ~pend_out) == '0));

   assert_reserved_frozen_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_gen && req_wdata[25:24] == 2'd3) |=> $stable(pend_out));

   assert_set_no_drop_R6: assert property (@(posedge clk) disable iff (!rst_n)
      wr_set |=> (($past(pend_out) & ~pend_out) == '0));

   assert_clear_no_rise_R7: assert property (@(posedge clk) disable iff (!rst_n)
      wr_clr |=> ((~$past(pend_out) & pend_out) == '0));

   assert_gen_reads_zero_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && !req_write && (req_win == 2'd0 || req_win == 2'd3)) |-> rd_data == '0);

   assert_idle_stable_R10: assert property (@(posedge clk) disable iff (!rst_n)
      !(req_valid && req_write) |=> $stable(pend_out));
endmodule

bind sgi_dispatch sgi_dispatch_chk #(.NUM_CPU(NUM_CPU), .NUM_SGI(NUM_SGI), .DATA_W(DATA_W)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .req_valid (req_valid),
   .req_write (req_write),
   .req_win   (req_win),
   .req_wdata (req_wdata),
   .rd_data   (rd_data),
   .pend_out  (pend_out)
);

// File: tb/sgi_dispatch_tb.sv
module sgi_dispatch_tb;
   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic [3:0]   active_cpus = 4'd4;
   logic         req_valid = 1'b0;
   logic         req_write = 1'b0;
   logic [1:0]   req_win = 2'd0;
   logic         req_byte = 1'b0;
   logic [3:0]   req_offset = '0;
   logic [2:0]   req_cpu = '0;
   logic [31:0]  req_wdata = '0;
   logic [31:0]  rd_data;
   logic [127:0] pend_out;

   int n_checks = 0;
   int n_fail = 0;

   logic [7:0]  exp_src [8][16];
   logic [31:0] q_exp[$];
   string       q_tag[$];

   always #5 clk = ~clk;

   sgi_dispatch u_dut (
      .clk(clk), .rst_n(rst_n), .active_cpus(active_cpus),
      .req_valid(req_valid), .req_write(req_write), .req_win(req_win),
      .req_byte(req_byte), .req_offset(req_offset), .req_cpu(req_cpu),
      .req_wdata(req_wdata), .rd_data(rd_data), .pend_out(pend_out)
   );

   task automatic note(input bit ok, input string tag, input logic [127:0] act, input logic [127:0] exp);
      n_checks++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   // Monitor: compare each read against the scoreboard queue.
   always @(negedge clk) begin
      if (rst_n && req_valid && !req_write) begin
         if (q_exp.size() == 0) note(1'b0, "read without expectation", 128'(rd_data), 128'd0);
         else begin
            logic [31:0] e;
            string t;
            e = q_exp.pop_front();
            t = q_tag.pop_front();
            note(rd_data === e, t, 128'(rd_data), 128'(e));
         end
      end
   end

   task automatic check_pend(input string tag);
      logic [127:0] e;
      for (int c = 0; c < 8; c++)
         for (int s = 0; s < 16; s++)
            e[c*16+s] = |exp_src[c][s];
      note(pend_out === e, tag, pend_out, e);
   endtask

   task automatic drive(input logic wr, input logic [2:0] cpu, input logic [1:0] win,
                        input logic isbyte, input logic [3:0] off, input logic [31:0] d);
      req_valid = 1'b1; req_write = wr; req_cpu = cpu; req_win = win;
      req_byte = isbyte; req_offset = off; req_wdata = d;
      @(posedge clk); #1;
      req_valid = 1'b0; req_write = 1'b0;
   endtask

   task automatic do_write(input logic [2:0] cpu, input logic [1:0] win, input logic isbyte,
                           input logic [3:0] off, input logic [31:0] d, input string tag);
      logic [7:0] tg;
      logic [3:0] base;
      if (win == 2'd0) begin
         tg = '0;
         case (d[25:24])
            2'd0: tg = d[23:16];
            2'd1: tg = 8'hFF & ~(8'h1 << cpu);
            2'd2: tg = 8'h1 << cpu;
            default: tg = '0;
         endcase
         for (int t = 0; t < 8; t++)
            if (tg[t] && t < int'(active_cpus)) exp_src[t][d[3:0]][cpu] = 1'b1;
      end else if (win == 2'd1 || win == 2'd2) begin
         base = isbyte ? off : {off[3:2], 2'b00};
         for (int k = 0; k < 4; k++) begin
            if (k == 0 || !isbyte) begin
               if (win == 2'd1) exp_src[cpu][base+4'(k)] |= d[8*k +: 8];
               else             exp_src[cpu][base+4'(k)] &= ~d[8*k +: 8];
            end
         end
      end
      drive(1'b1, cpu, win, isbyte, off, d);
      check_pend(tag);
   endtask

   task automatic do_read(input logic [2:0] cpu, input logic [1:0] win, input logic isbyte,
                          input logic [3:0] off, input string tag);
      logic [31:0] e;
      logic [3:0]  base;
      e = '0;
      if (win == 2'd1 || win == 2'd2) begin
         base = isbyte ? off : {off[3:2], 2'b00};
         for (int k = 0; k < 4; k++)
            if (k == 0 || !isbyte) e[8*k +: 8] = exp_src[cpu][base+4'(k)];
      end
      q_exp.push_back(e);
      q_tag.push_back(tag);
      drive(1'b0, cpu, win, isbyte, off, 32'hDEAD_BEEF);
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      n_checks++; n_fail++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
   end

   initial begin
      for (int c = 0; c < 8; c++)
         for (int s = 0; s < 16; s++) exp_src[c][s] = '0;
      repeat (3) @(posedge clk); #1;
      rst_n = 1'b1;
      @(posedge clk); #1;
      check_pend("R1 reset pending clear");
      do_read(3'd0, 2'd1, 1'b0, 4'd0, "R1 reset window read zero");
      do_read(3'd7, 2'd2, 1'b0, 4'd12, "R1 reset clear window read zero");

      // Mode 0: list 0xFF from CPU1, SGI5, active 4 -> CPUs 0..3 only
      do_write(3'd1, 2'd0, 1'b0, 4'd0, 32'h00FF_0005, "R2 list mode filtered by active count");
      do_read(3'd2, 2'd1, 1'b0, 4'd4, "R2 R9 CPU2 sees source CPU1 on SGI5");
      do_read(3'd5, 2'd1, 1'b0, 4'd4, "R2 CPU5 above active count untouched");
      // Mode 1 from CPU2, SGI3, list ignored
      do_write(3'd2, 2'd0, 1'b0, 4'd0, 32'h0100_0003, "R3 all active except writer");
      do_read(3'd2, 2'd2, 1'b1, 4'd3, "R3 writer bank has no SGI3");
      do_read(3'd3, 2'd2, 1'b1, 4'd3, "R3 CPU3 SGI3 source CPU2");
      // Mode 2 from CPU3, SGI15, list ignored
      do_write(3'd3, 2'd0, 1'b0, 4'd0, 32'h02F0_000F, "R4 writer only");
      do_read(3'd3, 2'd1, 1'b0, 4'd13, "R4 R8 word read SGI12..15 of CPU3");
      // Mode 3 reserved
      do_write(3'd0, 2'd0, 1'b0, 4'd0, 32'h03FF_0007, "R5 reserved mode no effect");
      do_read(3'd0, 2'd1, 1'b1, 4'd7, "R5 SGI7 still empty");
      do_read(3'd0, 2'd0, 1'b0, 4'd0, "R9 generate register reads zero");
      do_read(3'd0, 2'd3, 1'b0, 4'd0, "R9 unmapped window reads zero");

      // Set window byte write, CPU0 SGI9
      do_write(3'd0, 2'd1, 1'b1, 4'd9, 32'hFFFF_FF81, "R6 R8 byte set ORs source bits");
      do_read(3'd0, 2'd2, 1'b1, 4'd9, "R6 R9 byte read of SGI9");
      do_write(3'd0, 2'd2, 1'b1, 4'd9, 32'h0000_0001, "R7 partial clear keeps pending");
      do_read(3'd0, 2'd1, 1'b1, 4'd9, "R7 remaining source bit");
      do_write(3'd0, 2'd2, 1'b1, 4'd9, 32'h0000_0080, "R7 last bit cleared drops pending");
      do_write(3'd0, 2'd1, 1'b1, 4'd10, 32'h0000_0000, "R6 zero set leaves SGI idle");

      // Word set in CPU5 bank, offset 6 -> base 4
      do_write(3'd5, 2'd1, 1'b0, 4'd6, 32'h0403_0201, "R8 R11 word set lanes base 4");
      do_read(3'd5, 2'd1, 1'b0, 4'd4, "R8 word read SGI4..7 of CPU5");
      do_read(3'd0, 2'd1, 1'b0, 4'd4, "R11 CPU0 bank unaffected");
      do_read(3'd1, 2'd1, 1'b0, 4'd4, "R11 CPU1 bank keeps SGI5 only");
      do_write(3'd5, 2'd2, 1'b0, 4'd4, 32'h0400_0201, "R7 R8 word clear");
      do_read(3'd5, 2'd2, 1'b0, 4'd4, "R7 word read after clear");
      do_write(3'd1, 2'd2, 1'b1, 4'd5, 32'h0000_0002, "R11 CPU1 clears own SGI5");
      check_pend("R10 pending vector final");

      @(posedge clk); #1;
      note(q_exp.size() == 0, "scoreboard drained", 128'(q_exp.size()), 128'd0);
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
   end
endmodule